// File: doc/BRIEF.md
# Ones-Density Violation Monitor

This block watches a serial receive bit stream, one bit per accepted transfer, and judges it against two ones-density rules. The first rule flags a run of sixteen zeros in a row. The second rule is a family of nested windows: for every N from 1 to 23, the most recent 8(N+1) accepted bits must contain at least N ones. Window lengths therefore run from 16 bits to 192 bits.

A violation is reported in two ways. A status bit inverts, and a one-clock pulse marks the same cycle. One continuous violating stretch gives one report. The block re-arms only after every rule is satisfied again.

Bits arrive on a valid/ready interface. The block never applies back-pressure: `in_ready` is always high, so each cycle with `in_valid` high transfers one bit. Cycles with `in_valid` low transfer nothing and leave the bit history unchanged. Line decoding, framing and host access are handled elsewhere.

Top module: `pdv_monitor`

## Requirements
- R1: `in_ready` is high in every cycle, so a bit is accepted in every cycle where `in_valid` is high. `in_bit` has no effect in a cycle where `in_valid` is low.
- R2: While `rst_n` is low, and in the first cycle after it rises, `pdv_status` and `pdv_pulse` are 0. Reset also clears the bit history, the zero-run count and the received-bit count.
- R3: A violation condition holds when the last 16 accepted bits are all 0 (`in_bit` = 0 means a zero).
- R4: For each N from 1 to 23, a violation condition holds when the last 8(N+1) accepted bits contain fewer than N ones.
- R5: A window rule of length L is evaluated only once at least L bits have been accepted since reset. Before 16 bits have been accepted, no violation is reported.
- R6: A violation is reported in the cycle after the clock edge that accepts the offending bit. In that cycle `pdv_pulse` is high and `pdv_status` differs from its previous value. The pulse lasts exactly one cycle.
- R7: A new report needs the combined condition (R3 or any R4 window) to be false after some accepted bit. While the condition stays true, further bits give no report, so two pulses are never back to back.
- R8: `pdv_status` changes only in a cycle in which `pdv_pulse` is high.
- R9: Cycles with `in_valid` low neither break a zero run nor shift the windows. Counting resumes with the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A receive bit is offered this cycle |
| in_ready | output | 1 | Always high; the monitor accepts every offered bit |
| in_bit | input | 1 | Receive data bit, 1 = one, 0 = zero |
| pdv_status | output | 1 | Status bit; inverts on each reported violation |
| pdv_pulse | output | 1 | One-cycle strobe in the cycle `pdv_status` inverts |

## Verification
The assertions assume that `in_valid` and `in_bit` hold known values at every rising edge after reset, and that they change only between edges. They also assume that no transfer is lost, which holds because `in_ready` never drops. The bench keeps within these limits by driving both inputs on the falling edge with defined values, including in idle cycles where `in_bit` is deliberately random. It then walks through several streams: dense ones, exact 16-zero runs, sparse patterns that break only the long windows, gaps, and reset partway through a run. These streams let the zero-run check and the early-silence check see their trigger conditions.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
  // Length of the window tied to density index n: unit * (n + 1) bits.
  function automatic int unsigned pdv_win_len(input int unsigned n, input int unsigned unit);
    return unit * (n + 1);
  endfunction
endpackage

// File: rtl/pdv_history.sv
module pdv_history #(
  parameter int unsigned HIST = 192,
  parameter int unsigned ZRUN = 16,
  localparam int unsigned CW  = $clog2(HIST + 1),
  localparam int unsigned ZW  = $clog2(ZRUN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            bit_in,
  output logic [HIST-1:0] hist_q,
  output logic [CW-1:0]   fill_q,
  output logic            zrun_hit
);
  logic [ZW-1:0] zcnt_q;

  // Newest bit lives at index 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (take) begin
      hist_q <= {hist_q[HIST-2:0], bit_in};
    end
  end

  // Bits received since reset, held at HIST once full.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (take && (fill_q != CW'(HIST))) begin
      fill_q <= fill_q + CW'(1);
    end
  end

  // Current zero-run length, held at ZRUN.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt_q <= '0;
    end else if (take) begin
      if (bit_in) begin
        zcnt_q <= '0;
      end else if (zcnt_q != ZW'(ZRUN)) begin
        zcnt_q <= zcnt_q + ZW'(1);
      end
    end
  end

  // The bit being accepted completes a run of ZRUN zeros or more.
  assign zrun_hit = take && !bit_in && (zcnt_q >= ZW'(ZRUN - 1));
endmodule

// File: rtl/pdv_window_bank.sv
module pdv_window_bank
  import pdv_pkg::*;
#(
  parameter int unsigned UNIT = 8,
  parameter int unsigned NMAX = 23,
  parameter int unsigned HIST = 192,
  localparam int unsigned CW  = $clog2(HIST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            bit_in,
  input  logic [HIST-1:0] hist_q,
  input  logic [CW-1:0]   fill_q,
  output logic            short_any
);
  logic [NMAX-1:0] short_w;

  for (genvar n = 1; n <= NMAX; n++) begin : g_win
    localparam int unsigned LEN = pdv_win_len(n, UNIT);
    logic [CW-1:0] ones_q;
    logic [CW-1:0] ones_nxt;

    // Running count: add the bit entering, drop the bit leaving this window.
    assign ones_nxt = ones_q + CW'(bit_in) - CW'(hist_q[LEN-1]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ones_q <= '0;
      end else if (take) begin
        ones_q <= ones_nxt;
      end
    end

    // Rule applies once this bit brings the received total to LEN.
    assign short_w[n-1] = take && (fill_q >= CW'(LEN - 1)) && (ones_nxt < CW'(n));
  end

  assign short_any = |short_w;
endmodule

// File: rtl/pdv_event.sv
module pdv_event (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic cond_now,
  output logic level_q,
  output logic pulse_q,
  output logic status_q
);
  logic fire;

  assign fire = take && cond_now && !level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      pulse_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (take) begin
        level_q <= cond_now;
      end
      if (fire) begin
        status_q <= ~status_q;
      end
    end
  end
endmodule

// File: rtl/pdv_monitor.sv
module pdv_monitor
  import pdv_pkg::*;
#(
  parameter int unsigned UNIT = 8,
  parameter int unsigned NMAX = 23,
  parameter int unsigned ZRUN = 16,
  localparam int unsigned HIST = pdv_win_len(NMAX, UNIT),
  localparam int unsigned CW   = $clog2(HIST + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic pdv_status,
  output logic pdv_pulse
);
  logic            take;
  logic [HIST-1:0] hist_w;
  logic [CW-1:0]   fill_w;
  logic            zrun_w;
  logic            short_w;
  logic            level_w;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  pdv_history #(.HIST(HIST), .ZRUN(ZRUN)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .bit_in   (in_bit),
    .hist_q   (hist_w),
    .fill_q   (fill_w),
    .zrun_hit (zrun_w)
  );

  pdv_window_bank #(.UNIT(UNIT), .NMAX(NMAX), .HIST(HIST)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .bit_in    (in_bit),
    .hist_q    (hist_w),
    .fill_q    (fill_w),
    .short_any (short_w)
  );

  pdv_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .cond_now (zrun_w || short_w),
    .level_q  (level_w),
    .pulse_q  (pdv_pulse),
    .status_q (pdv_status)
  );
endmodule

// File: rtl/pdv_monitor_chk.sv
module pdv_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_bit,
  input logic pdv_status,
  input logic pdv_pulse,
  input logic viol_level
);
  logic [4:0] zc;
  logic [7:0] acc;
  logic       tk;

  assign tk = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc  <= '0;
      acc <= '0;
    end else if (tk) begin
      zc  <= in_bit ? 5'd0 : ((zc == 5'd31) ? zc : zc + 5'd1);
      acc <= (acc == 8'd255) ? acc : acc + 8'd1;
    end
  end

  p_pulse_flips_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pdv_pulse |-> (pdv_status != $past(pdv_status)));

  p_status_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pdv_pulse |-> $stable(pdv_status));

  p_pulse_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pdv_pulse |-> $past(in_valid && in_ready));

  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pdv_pulse |=> !pdv_pulse);

  p_zero_run_reported_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && !in_bit && (zc == 5'd15)) |=> (pdv_pulse || $past(viol_level)));

  p_silent_while_filling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && (acc < 8'd15)) |=> !pdv_pulse);
endmodule

bind pdv_monitor pdv_monitor_chk u_pdv_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_bit     (in_bit),
  .pdv_status (pdv_status),
  .pdv_pulse  (pdv_pulse),
  .viol_level (level_w)
);

// File: tb/test_pdv_monitor.sv
module test_pdv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int HIST_LEN   = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic pdv_status;
  logic pdv_pulse;

  int n_run = 0;
  int n_fail = 0;
  int pulses = 0;
  string tag = "R2";

  bit q[$];
  int zrun = 0;
  bit prev_lvl = 1'b0;
  bit exp_pulse = 1'b0;
  bit exp_status = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdv_monitor i_pdv_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_bit     (in_bit),
    .pdv_status (pdv_status),
    .pdv_pulse  (pdv_pulse)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    q.delete();
    zrun = 0;
    prev_lvl = 1'b0;
    exp_pulse = 1'b0;
    exp_status = 1'b0;
  endfunction

  // Behavioural model of the rules, run per clock edge.
  function automatic void model_step(input bit v, input bit b);
    bit lvl;
    exp_pulse = 1'b0;
    if (!v) return;
    q.push_front(b);
    if (q.size() > HIST_LEN) void'(q.pop_back());
    zrun = b ? 0 : zrun + 1;
    lvl = (zrun >= 16);
    for (int n = 1; n <= 23; n++) begin
      int len = 8 * (n + 1);
      if (q.size() >= len) begin
        int ones = 0;
        for (int k = 0; k < len; k++) ones += q[k];
        if (ones < n) lvl = 1'b1;
      end
    end
    exp_pulse = lvl && !prev_lvl;
    prev_lvl = lvl;
    if (exp_pulse) exp_status = ~exp_status;
  endfunction

  task automatic step(input bit v, input bit b);
    in_valid = v;
    in_bit = b;
    @(posedge clk);
    model_step(v, b);
    @(negedge clk);
    if (pdv_pulse === 1'b1) pulses++;
    check(tag, "pulse", pdv_pulse, exp_pulse);
    check(tag, "status", pdv_status, exp_status);
    check("R1", "ready", in_ready, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "pulse in reset", pdv_pulse, 1'b0);
    check("R2", "status in reset", pdv_status, 1'b0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R2", "pulse after reset", pdv_pulse, 1'b0);
    check("R2", "status after reset", pdv_status, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();

    // Dense ones: no violation anywhere.
    tag = "R4";
    for (int i = 0; i < 220; i++) step(1'b1, 1'b1);
    check("R4", "no report on dense ones", pdv_status, 1'b0);

    // Exactly sixteen zeros after ones.
    tag = "R3";
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
    check("R3", "silent at 15 zeros", pdv_pulse, 1'b0);
    step(1'b1, 1'b0);
    check("R3", "pulse at 16th zero", pdv_pulse, 1'b1);
    check("R6", "status inverted", pdv_status, 1'b1);
    step(1'b1, 1'b0);
    check("R6", "pulse one cycle", pdv_pulse, 1'b0);

    // Long run keeps a single report.
    tag = "R7";
    pulses = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    check("R7", "no repeat during run", pulses == 0, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
    check("R7", "re-armed after clear", pdv_pulse, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1);

    // One one every nine bits: short zero runs, long windows too sparse.
    tag = "R4";
    pulses = 0;
    for (int i = 0; i < 400; i++) step(1'b1, (i % 9) == 0);
    check("R4", "sparse window report", pulses > 0, 1'b1);
    // One in every eight bits meets every window.
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
    pulses = 0;
    for (int i = 0; i < 400; i++) step(1'b1, (i % 8) == 0);
    check("R4", "one per eight accepted", pulses == 0, 1'b1);

    // Gaps with random data must not break or shift counting.
    tag = "R9";
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
    pulses = 0;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'($urandom));
      step(1'b0, 1'b1);
    end
    check("R9", "zero run spans gaps", pulses == 1, 1'b1);
    tag = "R1";
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, 1'($urandom));

    // Reset partway, then fewer bits than any window.
    do_reset();
    tag = "R5";
    pulses = 0;
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
    check("R5", "silent before 16 bits", pulses == 0, 1'b1);
    step(1'b1, 1'b0);
    check("R5", "report once filled", pdv_pulse, 1'b1);

    // Mixed-density random streams.
    tag = "R4";
    for (int d = 5; d <= 40; d += 5) begin
      for (int i = 0; i < 500; i++) step(1'b1, ($urandom % 100) < d);
    end
    tag = "R6";
    for (int i = 0; i < 400; i++) step(($urandom % 4) != 0, ($urandom % 100) < 8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule